// File: doc/BRIEF.md
# Multichannel Acquisition Frame Sequencer

This block steps a measurement front end through one complete acquisition frame. A frame covers every channel of a 16-way analog multiplexer. For each reading, the sequencer does four things in order. It drives the channel address and a calibration offset code. It waits a programmable settling interval. It starts an external averaging engine and waits for that engine's busy flag to rise and then fall. Finally it issues a write strobe with the destination slot for the result. Each calibration channel in a configurable band is read twice. The second reading is taken one offset step lower, which gives a pair of results for that channel.

After the last channel, the sequencer enters a commit phase. It advances a wrapping frame counter and then waits for a host semaphore to clear. If the semaphore clears in time, it pulses a host-register commit. If a pause limit expires first, it raises a failure flag instead. In both cases it then pulses the internal-register commit and the offset commit, in that order. It then rests in an idle pause before the next frame starts. A 4-bit code for the current step is registered onto debug pins.

The averaging arithmetic and the ADC are outside this block. Bus decoding is also outside it. The averaging engine is seen only through a start pulse and a busy flag. The over-range and under-range flags from that engine are captured with each result.

Top module: `acq_seq`

## Requirements
- R1: While rst_n is low, every strobe (avg_start, wr_en, adj_clr, host_upd, int_upd, ofs_upd) is 0. mux_addr, frame_cnt, host_fail, ovr_q, und_q and dbg_state are all 0. cal_ofs equals the number of calibration channels (3 by default).
- R2: The sequencer idles for IDLE_PAUSE cycles before it starts a frame. The start of a frame is marked by a one-cycle adj_clr pulse. After reset release, adj_clr is first seen IDLE_PAUSE cycles later. After an ofs_upd pulse, the next adj_clr comes IDLE_PAUSE+1 cycles later.
- R3: avg_start pulses after the channel and offset outputs have been held unchanged for SETTLE_CYC settling cycles. The pulse comes SETTLE_CYC+1 cycles after adj_clr. It comes SETTLE_CYC+2 cycles after a write for channels outside CAL_FIRST..CAL_LAST. It comes SETTLE_CYC+3 cycles after a write for channels inside that band.
- R4: After avg_start, wr_en stays low until avg_busy has been seen high and then low. wr_en is asserted in the cycle after the cycle in which avg_busy is first seen low again.
- R5: A first reading of channel c is written to slot c. The second reading of calibration channel c is written to slot N_CHAN + (c − CAL_FIRST), which gives slots 16, 17 and 18 for channels 12, 13 and 14.
- R6: A frame makes exactly 19 writes, in channel order 0..15. Each calibration channel's second reading comes directly after its first. cal_ofs is 3 on channels 0..12 (first reading). It is one lower on each later reading: 2, 2, 1, 1, 0, and 0 on channel 15.
- R7: frame_cnt rises by exactly one per frame, after the channel-15 write, and wraps modulo 2^FRAME_W.
- R8: If host_lock is low during the host wait, host_upd, int_upd and ofs_upd pulse on three consecutive cycles and host_fail is 0 at int_upd. If host_lock drops partway through the wait, host_upd follows one cycle after the drop is sampled.
- R9: If host_lock stays high for HOST_PAUSE cycles of host wait, host_upd is skipped. host_fail is set, and it is already visible when int_upd pulses. int_upd follows HOST_PAUSE cycles after frame_cnt changes. ofs_upd comes one cycle after int_upd.
- R10: ovr_q and und_q take the values of rng_over and rng_under sampled in the wr_en cycle. They hold those values until the next write.
- R11: dbg_state shows the step code one cycle late. The codes are: idle 0x0, frame init 0x1, settle 0x2, start 0x3, wait busy high 0x4, wait busy low 0x5, write 0x6, pair check 0x7, re-measure step 0x8, channel advance 0x9, frame count 0xA, host wait 0xB, host commit 0xC, internal commit 0xD, offset commit 0xE. Code 0xF never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| avg_busy | input | 1 | Averaging engine busy flag |
| rng_over | input | 1 | Over-range flag from the averaging engine |
| rng_under | input | 1 | Under-range flag from the averaging engine |
| host_lock | input | 1 | Host semaphore; high blocks the host commit |
| mux_addr | output | CH_W (4) | Analog multiplexer channel address |
| cal_ofs | output | OFS_W (2) | Calibration offset code |
| avg_start | output | 1 | One-cycle start pulse to the averaging engine |
| wr_en | output | 1 | Result write strobe |
| wr_slot | output | SLOT_W (5) | Destination slot of the result |
| ovr_q | output | 1 | Over-range flag captured at the last write |
| und_q | output | 1 | Under-range flag captured at the last write |
| frame_cnt | output | FRAME_W | Completed-frame counter |
| adj_clr | output | 1 | Frame-start pulse that clears auto-range adjust flags |
| host_upd | output | 1 | Host-visible register commit pulse |
| int_upd | output | 1 | Internal register commit pulse |
| ofs_upd | output | 1 | Offset setting commit pulse |
| host_fail | output | 1 | Set when the host wait timed out; cleared on a host commit |
| dbg_state | output | 4 | Registered step code for debug pins |

## Verification
The bench builds the block with SETTLE_CYC=4, IDLE_PAUSE=3, HOST_PAUSE=6 and FRAME_W=2. The defaults need about 180,000 cycles of settling per reading. With the short values, every reading can be timed to the exact cycle and a whole frame runs in a few hundred cycles. The 2-bit frame counter makes wrap-around reachable on the fourth frame. The short host pause lets the bench exercise all three outcomes of the host wait: released at once, released partway through, and timed out.

// File: rtl/acq_seq_pkg.sv
// Package: shared step encoding for the acquisition sequencer.
// The numeric codes are exported on the debug pins and must stay fixed.
package acq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE    = 4'h0,
        ST_INIT    = 4'h1,
        ST_SETTLE  = 4'h2,
        ST_TRIG    = 4'h3,
        ST_WBUSY   = 4'h4,
        ST_WDONE   = 4'h5,
        ST_LATCH   = 4'h6,
        ST_CHKPAIR = 4'h7,
        ST_REMEAS  = 4'h8,
        ST_ADVANCE = 4'h9,
        ST_FRAME   = 4'hA,
        ST_HWAIT   = 4'hB,
        ST_HCOMMIT = 4'hC,
        ST_ICOMMIT = 4'hD,
        ST_OCOMMIT = 4'hE
    } acq_state_e;

endpackage

// File: rtl/acq_timer.sv
// Module: acq_timer
// Counts clock cycles while run is high and returns to zero whenever run
// is low. It saturates at all ones. Callers compare the count against
// their own limit.
// Assumes: run drops for at least one cycle between intervals that must
// start from zero.
module acq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] count
);

    // Cycle counter: clear while idle, saturating increment while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/acq_slot_map.sv
// Module: acq_slot_map
// Maps a channel and its pass flag to a result slot. First readings go to
// the slot equal to the channel number. Second readings of calibration
// channels go to the slots after the last channel.
// Assumes: second is only set for channels in CAL_FIRST..CAL_LAST.
module acq_slot_map #(
    parameter int N_CHAN    = 16,
    parameter int CAL_FIRST = 12,
    parameter int CH_W      = 4,
    parameter int SLOT_W    = 5
) (
    input  logic [CH_W-1:0]   chan,
    input  logic              second,
    output logic [SLOT_W-1:0] slot
);

    // Slot selection: plain channel index or the band after the channels
    always_comb begin
        if (second) begin
            slot = SLOT_W'(N_CHAN + int'(chan) - CAL_FIRST);
        end else begin
            slot = SLOT_W'(chan);
        end
    end

endmodule

// File: rtl/acq_seq_ctl.sv
// Module: acq_seq_ctl
// The step machine of the acquisition frame. It keeps the channel index,
// the pass flag and the calibration offset code. It decides each
// transition from the settle and pause counts, the averaging engine's
// busy flag and the host semaphore.
// Assumes: the settle and pause counts come from acq_timer instances that
// run in the settle state and in the idle/host-wait states respectively.
module acq_seq_ctl
    import acq_seq_pkg::*;
#(
    parameter int N_CHAN     = 16,
    parameter int CAL_FIRST  = 12,
    parameter int CAL_LAST   = 14,
    parameter int SETTLE_CYC = 180000,
    parameter int IDLE_PAUSE = 120000,
    parameter int HOST_PAUSE = 240,
    parameter int CH_W       = 4,
    parameter int OFS_W      = 2,
    parameter int SW         = 18,
    parameter int PW         = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    settle_cnt,
    input  logic [PW-1:0]    pause_cnt,
    input  logic             avg_busy,
    input  logic             host_lock,
    output acq_state_e       state,
    output logic [CH_W-1:0]  chan,
    output logic             second,
    output logic [OFS_W-1:0] cal_ofs,
    output logic             host_timeout
);

    localparam int N_CAL = CAL_LAST - CAL_FIRST + 1;
    localparam logic [OFS_W-1:0] OFS_PRESET = OFS_W'(N_CAL);
    localparam logic [CH_W-1:0]  LAST_CH    = CH_W'(N_CHAN - 1);
    localparam logic [SW-1:0]    SETTLE_END = SW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0]    IDLE_END   = PW'(IDLE_PAUSE - 1);
    localparam logic [PW-1:0]    HOST_END   = PW'(HOST_PAUSE - 1);

    acq_state_e state_nx;
    logic       in_cal;

    // Calibration band membership of the current channel
    always_comb begin
        in_cal = (int'(chan) >= CAL_FIRST) && (int'(chan) <= CAL_LAST);
    end

    // Host-wait expiry: semaphore still held when the pause limit is hit
    always_comb begin
        host_timeout = (state == ST_HWAIT) && host_lock && (pause_cnt >= HOST_END);
    end

    // Next-step selection; any code outside the list returns to idle
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:    if (pause_cnt >= IDLE_END) state_nx = ST_INIT;
            ST_INIT:    state_nx = ST_SETTLE;
            ST_SETTLE:  if (settle_cnt >= SETTLE_END) state_nx = ST_TRIG;
            ST_TRIG:    state_nx = ST_WBUSY;
            ST_WBUSY:   if (avg_busy) state_nx = ST_WDONE;
            ST_WDONE:   if (!avg_busy) state_nx = ST_LATCH;
            ST_LATCH: begin
                if (chan == LAST_CH)  state_nx = ST_FRAME;
                else if (in_cal)      state_nx = ST_CHKPAIR;
                else                  state_nx = ST_ADVANCE;
            end
            ST_CHKPAIR: state_nx = second ? ST_ADVANCE : ST_REMEAS;
            ST_REMEAS:  state_nx = ST_SETTLE;
            ST_ADVANCE: state_nx = ST_SETTLE;
            ST_FRAME:   state_nx = ST_HWAIT;
            ST_HWAIT: begin
                if (!host_lock)        state_nx = ST_HCOMMIT;
                else if (host_timeout) state_nx = ST_ICOMMIT;
            end
            ST_HCOMMIT: state_nx = ST_ICOMMIT;
            ST_ICOMMIT: state_nx = ST_OCOMMIT;
            ST_OCOMMIT: state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Channel index, pass flag and calibration offset bookkeeping per step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan    <= '0;
            second  <= 1'b0;
            cal_ofs <= OFS_PRESET;
        end else begin
            case (state)
                ST_INIT: begin
                    chan    <= '0;
                    second  <= 1'b0;
                    cal_ofs <= OFS_PRESET;
                end
                ST_REMEAS: begin
                    second  <= 1'b1;
                    cal_ofs <= cal_ofs - 1'b1;
                end
                ST_ADVANCE: begin
                    chan   <= chan + 1'b1;
                    second <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/acq_seq.sv
// Module: acq_seq (top)
// Acquisition frame sequencer. It ties the step machine to its settle and
// pause timers and to the slot map. It also holds the frame counter, the
// host-timeout flag, the captured range flags and the registered debug
// code.
// Assumes: avg_busy rises some time after avg_start and falls when the
// result and range flags are valid; host_lock is synchronous to clk.
module acq_seq
    import acq_seq_pkg::*;
#(
    parameter int N_CHAN     = 16,
    parameter int CAL_FIRST  = 12,
    parameter int CAL_LAST   = 14,
    parameter int SETTLE_CYC = 180000,
    parameter int IDLE_PAUSE = 120000,
    parameter int HOST_PAUSE = 240,
    parameter int FRAME_W    = 16,
    localparam int CH_W      = $clog2(N_CHAN),
    localparam int N_CAL     = CAL_LAST - CAL_FIRST + 1,
    localparam int OFS_W     = $clog2(N_CAL + 1),
    localparam int SLOT_W    = $clog2(N_CHAN + N_CAL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               avg_busy,
    input  logic               rng_over,
    input  logic               rng_under,
    input  logic               host_lock,
    output logic [CH_W-1:0]    mux_addr,
    output logic [OFS_W-1:0]   cal_ofs,
    output logic               avg_start,
    output logic               wr_en,
    output logic [SLOT_W-1:0]  wr_slot,
    output logic               ovr_q,
    output logic               und_q,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               adj_clr,
    output logic               host_upd,
    output logic               int_upd,
    output logic               ofs_upd,
    output logic               host_fail,
    output logic [3:0]         dbg_state
);

    localparam int PAUSE_MAX = (IDLE_PAUSE > HOST_PAUSE) ? IDLE_PAUSE : HOST_PAUSE;
    localparam int SW        = $clog2(SETTLE_CYC + 1);
    localparam int PW        = $clog2(PAUSE_MAX + 1);

    acq_state_e       state;
    logic [SW-1:0]    settle_cnt;
    logic [PW-1:0]    pause_cnt;
    logic             second;
    logic             host_timeout;
    logic             settle_run;
    logic             pause_run;

    // Timer enables: settle runs in its step, pause in idle and host wait
    always_comb begin
        settle_run = (state == ST_SETTLE);
        pause_run  = (state == ST_IDLE) || (state == ST_HWAIT);
    end

    acq_timer #(.W(SW)) u_settle_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (settle_run),
        .count (settle_cnt)
    );

    acq_timer #(.W(PW)) u_pause_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (pause_run),
        .count (pause_cnt)
    );

    acq_seq_ctl #(
        .N_CHAN     (N_CHAN),
        .CAL_FIRST  (CAL_FIRST),
        .CAL_LAST   (CAL_LAST),
        .SETTLE_CYC (SETTLE_CYC),
        .IDLE_PAUSE (IDLE_PAUSE),
        .HOST_PAUSE (HOST_PAUSE),
        .CH_W       (CH_W),
        .OFS_W      (OFS_W),
        .SW         (SW),
        .PW         (PW)
    ) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .settle_cnt   (settle_cnt),
        .pause_cnt    (pause_cnt),
        .avg_busy     (avg_busy),
        .host_lock    (host_lock),
        .state        (state),
        .chan         (mux_addr),
        .second       (second),
        .cal_ofs      (cal_ofs),
        .host_timeout (host_timeout)
    );

    acq_slot_map #(
        .N_CHAN    (N_CHAN),
        .CAL_FIRST (CAL_FIRST),
        .CH_W      (CH_W),
        .SLOT_W    (SLOT_W)
    ) u_slot_map (
        .chan   (mux_addr),
        .second (second),
        .slot   (wr_slot)
    );

    // Step-decoded strobes towards the averager and the register file
    always_comb begin
        adj_clr   = (state == ST_INIT);
        avg_start = (state == ST_TRIG);
        wr_en     = (state == ST_LATCH);
        host_upd  = (state == ST_HCOMMIT);
        int_upd   = (state == ST_ICOMMIT);
        ofs_upd   = (state == ST_OCOMMIT);
    end

    // Frame counter: one step per completed frame, wraps naturally
    always_ff @(posedge clk) begin
        if (!rst_n)                 frame_cnt <= '0;
        else if (state == ST_FRAME) frame_cnt <= frame_cnt + 1'b1;
    end

    // Host-timeout flag: set on expiry, cleared by a successful host commit
    always_ff @(posedge clk) begin
        if (!rst_n)            host_fail <= 1'b0;
        else if (host_timeout) host_fail <= 1'b1;
        else if (host_upd)     host_fail <= 1'b0;
    end

    // Range flag capture alongside each result write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            und_q <= 1'b0;
        end else if (wr_en) begin
            ovr_q <= rng_over;
            und_q <= rng_under;
        end
    end

    // Debug code register, one cycle behind the step register
    always_ff @(posedge clk) begin
        if (!rst_n) dbg_state <= 4'h0;
        else        dbg_state <= state;
    end

endmodule

// File: rtl/acq_seq_chk.sv
// Module: acq_seq_chk
// Assertion checker for acq_seq, attached by bind. It watches the ports
// only. It keeps two small trackers of its own: how long the channel and
// offset outputs have been stable, and whether busy was seen since the
// last start pulse.
module acq_seq_chk #(
    parameter int N_CHAN     = 16,
    parameter int CAL_FIRST  = 12,
    parameter int CAL_LAST   = 14,
    parameter int SETTLE_CYC = 180000,
    parameter int FRAME_W    = 16,
    localparam int CH_W      = $clog2(N_CHAN),
    localparam int N_CAL     = CAL_LAST - CAL_FIRST + 1,
    localparam int OFS_W     = $clog2(N_CAL + 1),
    localparam int SLOT_W    = $clog2(N_CHAN + N_CAL),
    localparam int KW        = $clog2(SETTLE_CYC + 1) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               avg_busy,
    input  logic [CH_W-1:0]    mux_addr,
    input  logic [OFS_W-1:0]   cal_ofs,
    input  logic               avg_start,
    input  logic               wr_en,
    input  logic [SLOT_W-1:0]  wr_slot,
    input  logic [FRAME_W-1:0] frame_cnt,
    input  logic               adj_clr,
    input  logic               host_upd,
    input  logic               int_upd,
    input  logic               ofs_upd,
    input  logic               host_fail,
    input  logic [3:0]         dbg_state
);

    logic [CH_W+OFS_W-1:0] key_q;
    logic [KW-1:0]         stab_q;
    logic                  seen_busy_q;

    // Stability tracker of the channel/offset pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q  <= '0;
            stab_q <= '0;
        end else begin
            key_q <= {mux_addr, cal_ofs};
            if ({mux_addr, cal_ofs} != key_q) stab_q <= '0;
            else if (stab_q != {KW{1'b1}})    stab_q <= stab_q + 1'b1;
        end
    end

    // Busy-seen tracker, rearmed by each start pulse
    always_ff @(posedge clk) begin
        if (!rst_n)         seen_busy_q <= 1'b0;
        else if (avg_start) seen_busy_q <= 1'b0;
        else if (avg_busy)  seen_busy_q <= 1'b1;
    end

    // R3
    settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avg_start |-> (stab_q >= KW'(SETTLE_CYC - 1)));

    // R4
    busy_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> seen_busy_q);

    // R5
    plain_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (mux_addr < CH_W'(CAL_FIRST))) |-> (wr_slot == SLOT_W'(mux_addr)));

    // R7
    frame_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frame_cnt) |-> (frame_cnt == $past(frame_cnt) + 1'b1));

    // R8
    host_then_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_upd |=> int_upd);

    // R8
    int_then_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_upd |=> ofs_upd);

    // R9
    fail_at_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_fail) |-> (int_upd && !host_upd));

    // R11
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_state != 4'hF);

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({adj_clr, avg_start, wr_en, host_upd, int_upd, ofs_upd}));

endmodule

bind acq_seq acq_seq_chk #(
    .N_CHAN     (N_CHAN),
    .CAL_FIRST  (CAL_FIRST),
    .CAL_LAST   (CAL_LAST),
    .SETTLE_CYC (SETTLE_CYC),
    .FRAME_W    (FRAME_W)
) u_acq_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .avg_busy  (avg_busy),
    .mux_addr  (mux_addr),
    .cal_ofs   (cal_ofs),
    .avg_start (avg_start),
    .wr_en     (wr_en),
    .wr_slot   (wr_slot),
    .frame_cnt (frame_cnt),
    .adj_clr   (adj_clr),
    .host_upd  (host_upd),
    .int_upd   (int_upd),
    .ofs_upd   (ofs_upd),
    .host_fail (host_fail),
    .dbg_state (dbg_state)
);

// File: tb/acq_seq_bench.sv
`timescale 1ns/1ps
// Directed bench for acq_seq: short timing parameters, a behavioural
// averager stub, and one task per scenario.
module acq_seq_bench;

    localparam int S  = 4;
    localparam int I  = 3;
    localparam int P  = 6;
    localparam int FW = 2;
    localparam int CF = 12;
    localparam int CL = 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          avg_busy = 1'b0;
    logic          rng_over = 1'b0;
    logic          rng_under = 1'b0;
    logic          host_lock = 1'b0;
    logic [3:0]    mux_addr;
    logic [1:0]    cal_ofs;
    logic          avg_start, wr_en, ovr_q, und_q;
    logic [4:0]    wr_slot;
    logic [FW-1:0] frame_cnt;
    logic          adj_clr, host_upd, int_upd, ofs_upd, host_fail;
    logic [3:0]    dbg_state;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int rec_slot [32];
    int rec_mux  [32];
    int rec_ofs  [32];
    int wr_idx = 0;

    always #2 clk = ~clk;

    acq_seq #(
        .SETTLE_CYC (S),
        .IDLE_PAUSE (I),
        .HOST_PAUSE (P),
        .FRAME_W    (FW)
    ) u_acq_seq (
        .clk (clk), .rst_n (rst_n), .avg_busy (avg_busy),
        .rng_over (rng_over), .rng_under (rng_under), .host_lock (host_lock),
        .mux_addr (mux_addr), .cal_ofs (cal_ofs), .avg_start (avg_start),
        .wr_en (wr_en), .wr_slot (wr_slot), .ovr_q (ovr_q), .und_q (und_q),
        .frame_cnt (frame_cnt), .adj_clr (adj_clr), .host_upd (host_upd),
        .int_upd (int_upd), .ofs_upd (ofs_upd), .host_fail (host_fail),
        .dbg_state (dbg_state)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Averager stub: busy after a channel-dependent delay, then drop with flags
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && avg_start) begin
                for (int k = 0; k < int'(mux_addr) % 3; k++) begin
                    @(negedge clk);
                    chk(wr_en == 1'b0, "R4 early write", int'(wr_en), 0);
                end
                avg_busy = 1'b1;
                for (int k = 0; k < 2 + int'(mux_addr) % 2; k++) begin
                    @(negedge clk);
                    chk(wr_en == 1'b0, "R4 write while busy", int'(wr_en), 0);
                end
                rng_over  = mux_addr[0] ^ mux_addr[2];
                rng_under = ~mux_addr[1];
                avg_busy  = 1'b0;
                @(negedge clk);
                chk(wr_en == 1'b1, "R4 write after busy", int'(wr_en), 1);
            end
        end
    end

    // Port monitor: write log, settle gap, flag capture, code lag at strobes
    int  since = 0;
    int  exp_gap = S + 1;
    bit  pend = 1'b0;
    logic exp_ov, exp_un;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                pend = 1'b0;
                chk(ovr_q == exp_ov, "R10 over flag", int'(ovr_q), int'(exp_ov));
                chk(und_q == exp_un, "R10 under flag", int'(und_q), int'(exp_un));
            end
            since++;
            if (adj_clr) begin
                since = 0;
                exp_gap = S + 1;
                wr_idx = 0;
            end
            if (avg_start) begin
                chk(since == exp_gap, "R3 settle gap", since, exp_gap);
                chk(dbg_state == 4'h2, "R11 code at start", int'(dbg_state), 2);
            end
            if (wr_en) begin
                if (wr_idx < 32) begin
                    rec_slot[wr_idx] = int'(wr_slot);
                    rec_mux[wr_idx]  = int'(mux_addr);
                    rec_ofs[wr_idx]  = int'(cal_ofs);
                end
                wr_idx++;
                chk(dbg_state == 4'h5, "R11 code at write", int'(dbg_state), 5);
                exp_gap = (int'(mux_addr) >= CF && int'(mux_addr) <= CL) ? S + 3 : S + 2;
                since = 0;
                exp_ov = rng_over;
                exp_un = rng_under;
                pend = 1'b1;
            end
        end
    end

    // Reset state scenario
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({avg_start, wr_en, adj_clr, host_upd, int_upd, ofs_upd} == 6'b0, "R1 strobes", 0, 0);
        chk(mux_addr == 4'd0, "R1 mux_addr", int'(mux_addr), 0);
        chk(cal_ofs == 2'd3, "R1 cal_ofs", int'(cal_ofs), 3);
        chk(frame_cnt == '0, "R1 frame_cnt", int'(frame_cnt), 0);
        chk(host_fail == 1'b0 && ovr_q == 1'b0 && und_q == 1'b0, "R1 flags", int'(host_fail), 0);
        chk(dbg_state == 4'h0, "R1 dbg_state", int'(dbg_state), 0);
    endtask

    // First idle interval after reset release
    task automatic t_first_idle();
        int k = 0;
        rst_n = 1'b1;
        do begin
            @(negedge clk);
            k++;
        end while (!adj_clr && k < 100);
        chk(k == I, "R2 idle after reset", k, I);
        chk(dbg_state == 4'h0, "R11 code at init", int'(dbg_state), 0);
        @(negedge clk);
        chk(dbg_state == 4'h1, "R11 init code lag", int'(dbg_state), 1);
    endtask

    // One frame; mode 0 lock free, 1 lock held (timeout), 2 release midway
    task automatic t_frame(input int mode);
        logic [FW-1:0] fc0 = frame_cnt;
        int idx = 0;
        int g = 0;
        bit saw_host = 1'b0;
        host_lock = (mode != 0);
        while (frame_cnt == fc0) @(negedge clk);
        chk(frame_cnt == FW'(fc0 + 1'b1), "R7 frame step", int'(frame_cnt), int'(FW'(fc0 + 1'b1)));
        chk(wr_idx == 19, "R6 write count", wr_idx, 19);
        for (int c = 0; c < 16; c++) begin
            int o1 = (c < CF) ? 3 : 3 - (c - CF);
            chk(rec_mux[idx] == c, "R6 channel order", rec_mux[idx], c);
            chk(rec_slot[idx] == c, "R5 first slot", rec_slot[idx], c);
            chk(rec_ofs[idx] == o1, "R6 first offset", rec_ofs[idx], o1);
            idx++;
            if (c >= CF && c <= CL) begin
                chk(rec_mux[idx] == c, "R6 pair order", rec_mux[idx], c);
                chk(rec_slot[idx] == 16 + c - CF, "R5 second slot", rec_slot[idx], 16 + c - CF);
                chk(rec_ofs[idx] == o1 - 1, "R6 second offset", rec_ofs[idx], o1 - 1);
                idx++;
            end
        end
        while (!int_upd && g < 50) begin
            @(negedge clk);
            g++;
            if (mode == 2 && g == 2) host_lock = 1'b0;
            if (host_upd) begin
                saw_host = 1'b1;
                chk(dbg_state == 4'hB, "R11 code at host commit", int'(dbg_state), 11);
            end
        end
        host_lock = 1'b0;
        if (mode == 1) begin
            chk(g == P, "R9 timeout length", g, P);
            chk(!saw_host, "R9 host commit skipped", int'(saw_host), 0);
            chk(host_fail == 1'b1, "R9 fail flag", int'(host_fail), 1);
            chk(dbg_state == 4'hB, "R11 code after wait", int'(dbg_state), 11);
        end else begin
            chk(g == ((mode == 2) ? 4 : 2), "R8 commit timing", g, (mode == 2) ? 4 : 2);
            chk(saw_host, "R8 host commit seen", int'(saw_host), 1);
            chk(host_fail == 1'b0, "R8 fail flag clear", int'(host_fail), 0);
            chk(dbg_state == 4'hC, "R11 code after host commit", int'(dbg_state), 12);
        end
        @(negedge clk);
        chk(ofs_upd == 1'b1, "R8 offset commit follows", int'(ofs_upd), 1);
        chk(dbg_state == 4'hD, "R11 code at offset commit", int'(dbg_state), 13);
        g = 0;
        do begin
            @(negedge clk);
            g++;
            if (g == 1) chk(dbg_state == 4'hE, "R11 code after commit", int'(dbg_state), 14);
        end while (!adj_clr && g < 100);
        chk(g == I + 1, "R2 idle between frames", g, I + 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_first_idle();
        t_frame(0);
        t_frame(1);
        t_frame(2);
        t_frame(0);
        chk(frame_cnt == '0, "R7 wrap", int'(frame_cnt), 0);
        t_frame(1);
        finish_run();
    end

endmodule